// File: doc/BRIEF.md
# Dual-Channel Frequency Sweep Sequencer

This controller steps two measurement channels, one for voltage and one for current, through a logarithmic frequency sweep from the highest decade down to the lowest. The two channels share one clock and one tuning word. For every frequency point the sequencer picks a clock subrange and a tuning word. It sends a start to both channels in the same cycle and waits until each channel has reported completion. It then presents the four captured result components: real and imaginary parts of voltage and of current.

The sweep has seven decades of equally spaced points. The highest decade is the fastest one and is walked first. Steps inside a decade are walked in descending order, and repetitions of one point, used for averaging, form the innermost loop. Each subrange is a tenfold slower clock than the one above it. Inside a subrange only the tuning word changes. The word is chosen so that every point covers a whole number of signal periods. A settling-period count is passed unchanged to the channels so that they can run extra periods before they acquire data. A wait counter guards against a channel that never finishes.

States: IDLE, CONFIG, START, WAIT, LATCH, NEXT, DONE. The transitions are:
- IDLE goes to CONFIG on `sweep_go`.
- CONFIG always goes to START.
- START always goes to WAIT.
- WAIT goes to LATCH once both channels are complete. It goes to IDLE, with the error flag set, when the wait expires.
- LATCH always goes to NEXT.
- NEXT goes to START for another repetition, to CONFIG for a new frequency, or to DONE after the final point.
- DONE always goes to IDLE.

Top module: `sweep_sequencer`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `vch_start`, `ich_start`, `res_valid`, `sweep_done` and `err_timeout` are all 0.
- R2: Decade index 0 (highest) and decade 1 both use subrange 0, and decade d ≥ 1 uses subrange d−1, so `clk_sel` runs from 0 to 5. `clk_sel` and `tune_word` do not change while a point is being measured.
- R3: The tuning word is step × 2^16 in decades 1..6 and step × 10 × 2^16 in decade 0. Both start outputs rise in the same cycle for exactly one cycle.
- R4: Points are visited decade 0 to 6. Steps run 10 down to 1 in decade 0 and 9 down to 1 in the other decades, which gives 64 points per pass. Repetition indices form the innermost loop.
- R5: The sequencer proceeds only after it has seen both done inputs, in either order or together. Each channel's two components are taken in the cycle in which that channel's done is high.
- R6: `res_valid` is high for exactly one cycle per measurement, in the cycle after the second done. It carries the decade, step and repetition indices and the four components.
- R7: Counting from the start pulse, the sequencer waits at most TIMEOUT cycles. If both dones have not been seen by then, it returns to idle with `err_timeout` set and produces no result. A done that completes the pair in the final allowed cycle wins over expiry.
- R8: After the final point, `sweep_done` pulses for one cycle and `busy` is 0 in the following cycle.
- R9: Each point is measured `cfg_repeat`+1 times, with repetition index 0 upward. `cfg_repeat` is taken when the sweep starts.
- R10: `settle_out` equals the `cfg_settle` value taken when the sweep starts and holds that value for the whole sweep, even if the input changes.
- R11: Done inputs are ignored outside the waiting state, and `sweep_go` is ignored while busy.
- R12: `err_timeout` stays set until the next accepted `sweep_go`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sweep_go | input | 1 | Begin a sweep (accepted when idle) |
| cfg_repeat | input | REP_W | Extra repetitions per point |
| cfg_settle | input | SETTLE_W | Settling periods passed to the channels |
| vch_start | output | 1 | Start pulse to the voltage channel |
| ich_start | output | 1 | Start pulse to the current channel |
| vch_done | input | 1 | Voltage channel finished |
| ich_done | input | 1 | Current channel finished |
| vch_re | input | DATA_W | Voltage real part, valid with vch_done |
| vch_im | input | DATA_W | Voltage imaginary part, valid with vch_done |
| ich_re | input | DATA_W | Current real part, valid with ich_done |
| ich_im | input | DATA_W | Current imaginary part, valid with ich_done |
| clk_sel | output | SUB_W | Clock subrange select |
| tune_word | output | TW_W | Shared tuning word |
| settle_out | output | SETTLE_W | Settling-period count for the channels |
| busy | output | 1 | Sweep in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_decade | output | DEC_W | Decade index of the result |
| res_step | output | STEP_W | Step index of the result |
| res_rep | output | REP_W | Repetition index of the result |
| res_v_re | output | DATA_W | Latched voltage real part |
| res_v_im | output | DATA_W | Latched voltage imaginary part |
| res_i_re | output | DATA_W | Latched current real part |
| res_i_im | output | DATA_W | Latched current imaginary part |
| sweep_done | output | 1 | One-cycle end-of-sweep strobe |
| err_timeout | output | 1 | A channel failed to finish in time |

## Verification
Completion of the channel pair and expiry of the wait counter can fall in the same cycle. The bench provokes this by holding back the voltage channel's done until exactly the last allowed waiting cycle of the first point. It then delays that channel by one cycle more on the second point. The first point must yield a result with `err_timeout` low, and the second must end the sweep with `err_timeout` set and no further result. A behavioural model also compares the start pairing, subrange, tuning word, settling count and result payload against a precomputed point list on every clock, while the two channels answer in alternating orders.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CONFIG = 3'd1,
        ST_START  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_LATCH  = 3'd4,
        ST_NEXT   = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_t;

endpackage

// File: rtl/sweep_freq_plan.sv
// Maps (decade, step) to a clock subrange and a tuning word.
module sweep_freq_plan #(
    parameter int NUM_DECADES = 7,
    parameter int DEC_W       = 3,
    parameter int STEP_W      = 4,
    parameter int SUB_W       = 3,
    parameter int TW_W        = 27,
    parameter int TW_SHIFT    = 16,
    parameter int TOP_SCALE   = 10
) (
    input  logic [DEC_W-1:0]  decade,
    input  logic [STEP_W-1:0] step,
    output logic [SUB_W-1:0]  clk_sel,
    output logic [TW_W-1:0]   tune_word
);

    logic [TW_W-1:0] periods;

    // The two highest decades share the fastest subrange.
    always_comb begin
        if (decade == '0) begin
            clk_sel = '0;
        end else begin
            clk_sel = SUB_W'(decade - DEC_W'(1));
        end
    end

    generate
        if (TOP_SCALE == 1) begin : g_flat
            always_comb begin
                periods = TW_W'(step);
            end
        end else begin : g_scaled
            always_comb begin
                if (decade == '0) begin
                    periods = TW_W'(step) * TW_W'(TOP_SCALE);
                end else begin
                    periods = TW_W'(step);
                end
            end
        end
    endgenerate

    always_comb begin
        tune_word = periods << TW_SHIFT;
    end

endmodule

// File: rtl/sweep_chan_capture.sv
// Remembers that one channel finished and holds its two components.
module sweep_chan_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              done,
    input  logic [DATA_W-1:0] re_in,
    input  logic [DATA_W-1:0] im_in,
    output logic              seen,
    output logic [DATA_W-1:0] re_q,
    output logic [DATA_W-1:0] im_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 1'b0;
            re_q <= '0;
            im_q <= '0;
        end else if (clear) begin
            seen <= 1'b0;
        end else if (enable && done && !seen) begin
            seen <= 1'b1;
            re_q <= re_in;
            im_q <= im_in;
        end
    end

endmodule

// File: rtl/sweep_wait_timer.sv
// Counts waiting cycles; expired marks the last allowed cycle.
module sweep_wait_timer #(
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run && !expired) begin
            count <= count + CNT_W'(1);
        end
    end

    always_comb begin
        expired = (count == CNT_W'(TIMEOUT - 1));
    end

endmodule

// File: rtl/sweep_sequencer.sv
module sweep_sequencer
    import sweep_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NUM_DECADES = 7,
    parameter int TOP_STEPS   = 10,
    parameter int LOW_STEPS   = 9,
    parameter int TOP_SCALE   = 10,
    parameter int TW_W        = 27,
    parameter int TW_SHIFT    = 16,
    parameter int REP_W       = 4,
    parameter int SETTLE_W    = 8,
    parameter int TIMEOUT     = 1 << 20,
    localparam int DEC_W      = $clog2(NUM_DECADES),
    localparam int STEP_W     = $clog2(TOP_STEPS + 1),
    localparam int SUB_W      = $clog2(NUM_DECADES - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sweep_go,
    input  logic [REP_W-1:0]    cfg_repeat,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output logic                vch_start,
    output logic                ich_start,
    input  logic                vch_done,
    input  logic                ich_done,
    input  logic [DATA_W-1:0]   vch_re,
    input  logic [DATA_W-1:0]   vch_im,
    input  logic [DATA_W-1:0]   ich_re,
    input  logic [DATA_W-1:0]   ich_im,
    output logic [SUB_W-1:0]    clk_sel,
    output logic [TW_W-1:0]     tune_word,
    output logic [SETTLE_W-1:0] settle_out,
    output logic                busy,
    output logic                res_valid,
    output logic [DEC_W-1:0]    res_decade,
    output logic [STEP_W-1:0]   res_step,
    output logic [REP_W-1:0]    res_rep,
    output logic [DATA_W-1:0]   res_v_re,
    output logic [DATA_W-1:0]   res_v_im,
    output logic [DATA_W-1:0]   res_i_re,
    output logic [DATA_W-1:0]   res_i_im,
    output logic                sweep_done,
    output logic                err_timeout
);

    localparam logic [DEC_W-1:0]  LAST_DECADE = DEC_W'(NUM_DECADES - 1);
    localparam logic [STEP_W-1:0] FIRST_TOP   = STEP_W'(TOP_STEPS);
    localparam logic [STEP_W-1:0] FIRST_LOW   = STEP_W'(LOW_STEPS);

    seq_state_t state_q, state_d;

    logic [DEC_W-1:0]    decade_q;
    logic [STEP_W-1:0]   step_q;
    logic [REP_W-1:0]    rep_q;
    logic [REP_W-1:0]    rep_limit_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                err_q;

    logic v_seen, i_seen;
    logic pair_done;
    logic wait_expired;
    logic last_rep, last_step, last_decade;
    logic in_start, in_wait;

    // ---------------- sub-blocks ----------------
    sweep_freq_plan #(
        .NUM_DECADES (NUM_DECADES),
        .DEC_W       (DEC_W),
        .STEP_W      (STEP_W),
        .SUB_W       (SUB_W),
        .TW_W        (TW_W),
        .TW_SHIFT    (TW_SHIFT),
        .TOP_SCALE   (TOP_SCALE)
    ) u_plan (
        .decade    (decade_q),
        .step      (step_q),
        .clk_sel   (clk_sel),
        .tune_word (tune_word)
    );

    sweep_chan_capture #(.DATA_W(DATA_W)) u_vcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (in_start),
        .enable (in_wait),
        .done   (vch_done),
        .re_in  (vch_re),
        .im_in  (vch_im),
        .seen   (v_seen),
        .re_q   (res_v_re),
        .im_q   (res_v_im)
    );

    sweep_chan_capture #(.DATA_W(DATA_W)) u_icap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (in_start),
        .enable (in_wait),
        .done   (ich_done),
        .re_in  (ich_re),
        .im_in  (ich_im),
        .seen   (i_seen),
        .re_q   (res_i_re),
        .im_q   (res_i_im)
    );

    sweep_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (in_start),
        .run     (in_wait),
        .expired (wait_expired)
    );

    // ---------------- decode helpers ----------------
    always_comb begin
        in_start    = (state_q == ST_START);
        in_wait     = (state_q == ST_WAIT);
        pair_done   = (v_seen || vch_done) && (i_seen || ich_done);
        last_rep    = (rep_q == rep_limit_q);
        last_step   = (step_q == STEP_W'(1));
        last_decade = (decade_q == LAST_DECADE);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sweep_go) begin
                    state_d = ST_CONFIG;
                end
            end
            ST_CONFIG: state_d = ST_START;
            ST_START:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (pair_done) begin
                    state_d = ST_LATCH;
                end else if (wait_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LATCH: state_d = ST_NEXT;
            ST_NEXT: begin
                if (!last_rep) begin
                    state_d = ST_START;
                end else if (last_step && last_decade) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_CONFIG;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- sweep position and configuration ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            decade_q    <= '0;
            step_q      <= FIRST_TOP;
            rep_q       <= '0;
            rep_limit_q <= '0;
            settle_q    <= '0;
            err_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sweep_go) begin
                        decade_q    <= '0;
                        step_q      <= FIRST_TOP;
                        rep_q       <= '0;
                        rep_limit_q <= cfg_repeat;
                        settle_q    <= cfg_settle;
                        err_q       <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (!pair_done && wait_expired) begin
                        err_q <= 1'b1;
                    end
                end
                ST_NEXT: begin
                    if (!last_rep) begin
                        rep_q <= rep_q + REP_W'(1);
                    end else begin
                        rep_q <= '0;
                        if (!last_step) begin
                            step_q <= step_q - STEP_W'(1);
                        end else if (!last_decade) begin
                            step_q   <= FIRST_LOW;
                            decade_q <= decade_q + DEC_W'(1);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        vch_start   = 1'b0;
        ich_start   = 1'b0;
        res_valid   = 1'b0;
        sweep_done  = 1'b0;
        busy        = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy       = 1'b0;
            ST_START: begin
                vch_start = 1'b1;
                ich_start = 1'b1;
            end
            ST_LATCH: res_valid  = 1'b1;
            ST_DONE:  sweep_done = 1'b1;
            default: begin
            end
        endcase
        res_decade  = decade_q;
        res_step    = step_q;
        res_rep     = rep_q;
        settle_out  = settle_q;
        err_timeout = err_q;
    end

endmodule

// File: rtl/sweep_sequencer_sva.sv
module sweep_sequencer_sva #(
    parameter int NUM_DECADES = 7,
    parameter int TW_W        = 27,
    parameter int SETTLE_W    = 8,
    parameter int TIMEOUT     = 1024,
    localparam int SUB_W      = $clog2(NUM_DECADES - 1),
    localparam int CW         = $clog2(TIMEOUT + 3)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                vch_start,
    input logic                ich_start,
    input logic                res_valid,
    input logic                sweep_done,
    input logic                busy,
    input logic                err_timeout,
    input logic [SUB_W-1:0]    clk_sel,
    input logic [TW_W-1:0]     tune_word,
    input logic [SETTLE_W-1:0] settle_out
);

    logic [CW-1:0] since_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_start <= '0;
        end else if (vch_start) begin
            since_start <= CW'(1);
        end else if (since_start != '0 && busy && !res_valid) begin
            since_start <= since_start + CW'(1);
        end else begin
            since_start <= '0;
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (vch_start || ich_start) |=> (!vch_start && !ich_start)); // R3
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(clk_sel) < NUM_DECADES - 1)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        vch_start |=> ($stable(clk_sel) && $stable(tune_word))); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R6
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(since_start) <= TIMEOUT + 1); // R7
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> !busy); // R7
    AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !busy); // R8
    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(settle_out)); // R10

endmodule

bind sweep_sequencer sweep_sequencer_sva #(
    .NUM_DECADES (NUM_DECADES),
    .TW_W        (TW_W),
    .SETTLE_W    (SETTLE_W),
    .TIMEOUT     (TIMEOUT)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .vch_start   (vch_start),
    .ich_start   (ich_start),
    .res_valid   (res_valid),
    .sweep_done  (sweep_done),
    .busy        (busy),
    .err_timeout (err_timeout),
    .clk_sel     (clk_sel),
    .tune_word   (tune_word),
    .settle_out  (settle_out)
);

// File: tb/sweep_sequencer_bench.sv
`timescale 1ns/1ps
module sweep_sequencer_bench;

    localparam int TO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sweep_go = 1'b0;
    logic [3:0]  cfg_repeat = '0;
    logic [7:0]  cfg_settle = '0;
    logic        vch_start, ich_start;
    logic        vch_done = 1'b0, ich_done = 1'b0;
    logic [15:0] vch_re = '0, vch_im = '0, ich_re = '0, ich_im = '0;
    logic [2:0]  clk_sel;
    logic [26:0] tune_word;
    logic [7:0]  settle_out;
    logic        busy, res_valid, sweep_done, err_timeout;
    logic [2:0]  res_decade;
    logic [3:0]  res_step, res_rep;
    logic [15:0] res_v_re, res_v_im, res_i_re, res_i_im;

    always #5 clk = ~clk;

    sweep_sequencer #(.TIMEOUT(TO)) u_sweep_sequencer (
        .clk(clk), .rst_n(rst_n), .sweep_go(sweep_go),
        .cfg_repeat(cfg_repeat), .cfg_settle(cfg_settle),
        .vch_start(vch_start), .ich_start(ich_start),
        .vch_done(vch_done), .ich_done(ich_done),
        .vch_re(vch_re), .vch_im(vch_im), .ich_re(ich_re), .ich_im(ich_im),
        .clk_sel(clk_sel), .tune_word(tune_word), .settle_out(settle_out),
        .busy(busy), .res_valid(res_valid),
        .res_decade(res_decade), .res_step(res_step), .res_rep(res_rep),
        .res_v_re(res_v_re), .res_v_im(res_v_im),
        .res_i_re(res_i_re), .res_i_im(res_i_im),
        .sweep_done(sweep_done), .err_timeout(err_timeout)
    );

    int checks = 0;
    int errors = 0;
    int mode = 0;          // 0 normal, 1 voltage silent, 2 boundary
    int exp_d[$], exp_s[$], exp_r[$];
    int pstart = 0, pres = 0;
    int exp_settle = 0;
    bit mon_on = 1'b0;
    bit summary_done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic build_plan(input int reps);
        exp_d.delete(); exp_s.delete(); exp_r.delete();
        for (int d = 0; d < 7; d++) begin
            for (int s = (d == 0) ? 10 : 9; s >= 1; s--) begin
                for (int r = 0; r <= reps; r++) begin
                    exp_d.push_back(d); exp_s.push_back(s); exp_r.push_back(r);
                end
            end
        end
    endtask

    function automatic int dly_v(input int k);
        if (mode == 1) return 0;
        if (mode == 2) return (k == 0) ? TO : TO + 1;
        return 1 + (k % 4);
    endfunction

    function automatic int dly_i(input int k);
        if (mode != 0) return 1;
        return 1 + ((k * 3 + 2) % 5);
    endfunction

    // voltage channel model
    int vn = 0;
    initial begin
        forever begin
            @(negedge clk);
            vch_done = 1'b0; vch_re = 16'hDEAD; vch_im = 16'hDEAD;
            if (vch_start) begin
                automatic int k = vn;
                automatic int d = dly_v(k);
                vn++;
                if (d > 0) begin
                    repeat (d) @(negedge clk);
                    vch_done = 1'b1;
                    vch_re = 16'(k * 8 + 1);
                    vch_im = 16'(k * 8 + 2);
                end
            end
        end
    end

    // current channel model
    int in_cnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            ich_done = 1'b0; ich_re = 16'hBEEF; ich_im = 16'hBEEF;
            if (ich_start) begin
                automatic int k = in_cnt;
                automatic int d = dly_i(k);
                in_cnt++;
                repeat (d) @(negedge clk);
                ich_done = 1'b1;
                ich_re = 16'(16'hA000 + k);
                ich_im = 16'(16'h5000 - k);
            end
        end
    end

    // reference model comparison on every clock
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (vch_start !== ich_start)
                    chk(1'b0, "R3", "start pairing", vch_start, ich_start);
                if (vch_start && pstart < exp_d.size()) begin
                    automatic int d = exp_d[pstart];
                    automatic int s = exp_s[pstart];
                    automatic longint tw = (d == 0) ? s * 10 * 65536 : s * 65536;
                    chk(clk_sel == 3'((d == 0) ? 0 : d - 1), "R2", "clk_sel", clk_sel, (d == 0) ? 0 : d - 1);
                    chk(tune_word == 27'(tw), "R3", "tune_word", tune_word, tw);
                    chk(settle_out == 8'(exp_settle), "R10", "settle_out", settle_out, exp_settle);
                    pstart++;
                end
                if (res_valid) begin
                    if (pres >= exp_d.size()) begin
                        chk(1'b0, "R4", "extra result", pres, exp_d.size());
                    end else begin
                        automatic int k = pres;
                        chk(res_decade == 3'(exp_d[k]), "R4", "decade", res_decade, exp_d[k]);
                        chk(res_step == 4'(exp_s[k]), "R4", "step", res_step, exp_s[k]);
                        chk(res_rep == 4'(exp_r[k]), "R9", "rep", res_rep, exp_r[k]);
                        chk(res_v_re == 16'(k * 8 + 1) && res_v_im == 16'(k * 8 + 2),
                            "R5", "voltage data", res_v_re, 16'(k * 8 + 1));
                        chk(res_i_re == 16'(16'hA000 + k) && res_i_im == 16'(16'h5000 - k),
                            "R6", "current data", res_i_re, 16'(16'hA000 + k));
                    end
                    pres++;
                end
            end
        end
    end

    task automatic go_pulse();
        @(negedge clk); sweep_go = 1'b1;
        @(negedge clk); sweep_go = 1'b0;
    endtask

    task automatic prep(input int reps, input int m);
        mode = m; build_plan(reps);
        pstart = 0; pres = 0; vn = 0; in_cnt = 0;
        cfg_repeat = 4'(reps);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int done_seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !vch_start && !ich_start && !res_valid && !sweep_done && !err_timeout,
            "R1", "reset outputs", busy, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // full sweep, no repeats, channels answering in varying order
        prep(0, 0); exp_settle = 5; cfg_settle = 8'd5;
        go_pulse();
        repeat (30) @(negedge clk);
        // R10 / R11: config change and go while busy have no effect
        cfg_settle = 8'd99; cfg_repeat = 4'd3;
        sweep_go = 1'b1; @(negedge clk); sweep_go = 1'b0;
        done_seen = 0;
        while (!sweep_done && busy) @(negedge clk);
        done_seen = sweep_done;
        chk(done_seen == 1, "R8", "sweep_done pulse", done_seen, 1);
        @(negedge clk);
        chk(!busy, "R8", "idle after done", busy, 0);
        chk(pres == 64, "R4", "points per pass", pres, 64);
        chk(settle_out == 8'd5, "R10", "settle held", settle_out, 5);

        // repeats for averaging
        prep(2, 0); exp_settle = 7; cfg_settle = 8'd7;
        go_pulse();
        wait_idle();
        chk(pres == 192, "R9", "measurements with repeats", pres, 192);
        chk(pstart == 192, "R3", "start count", pstart, 192);

        // R11: done inputs ignored while idle
        pres = 0;
        @(negedge clk); vch_done = 1'b1; ich_done = 1'b1;
        repeat (4) @(negedge clk);
        chk(!busy && pres == 0, "R11", "done while idle", pres, 0);

        // R7: voltage channel silent
        prep(0, 1);
        go_pulse();
        wait_idle();
        chk(err_timeout == 1'b1, "R7", "timeout flag", err_timeout, 1);
        chk(pres == 0, "R7", "no result on timeout", pres, 0);
        chk(pstart == 1, "R7", "single attempt", pstart, 1);
        repeat (50) @(negedge clk);
        chk(err_timeout == 1'b1, "R12", "flag sticky", err_timeout, 1);

        // R7 boundary: completion in last cycle wins, one cycle later loses
        prep(0, 2);
        @(negedge clk); sweep_go = 1'b1;
        @(negedge clk); sweep_go = 1'b0;
        chk(err_timeout == 1'b0, "R12", "flag cleared by go", err_timeout, 0);
        wait_idle();
        chk(pres == 1, "R7", "last-cycle completion kept", pres, 1);
        chk(err_timeout == 1'b1, "R7", "late done times out", err_timeout, 1);
        repeat (60) @(negedge clk);
        chk(pres == 1 && !busy, "R11", "late done ignored", pres, 1);

        finish_run();
    end

endmodule